// File: doc/BRIEF.md
# Sync Point Wait Evaluator

This block keeps a bank of 32-bit sync point counters and a bank of 32-bit base registers. It decides whether a channel's pending wait command has been met. A wait arrives as one 32-bit word in one of two forms. The direct form carries a sync point index and a 24-bit literal threshold. The base-relative form carries a sync point index, a base register index and a 16-bit offset, and the threshold is the base register's content plus that offset.

Counters advance by one through an increment port. Base registers are loaded through a write port. Once a wait is accepted it stays pending, and the command stream stays stalled, until the wait is met. A one-cycle done pulse then releases it.

While a wait is pending, the block shows a debug view of the blocked channel:
- a class code;
- a method offset, which tells the two wait forms apart;
- the raw command word;
- the effective threshold.

Top module: `syncpt_wait_eval`

## Requirements
- R1: After reset the block is idle. `wait_ready_o`=1, while `busy_o`, `done_o` and `err_o` are 0, and `dbg_class_o`, `dbg_method_o`, `dbg_word_o` and `thr_o` are all 0.
- R2: Direct form (`wait_base_i`=0): word bits 31:24 select the sync point and bits 23:0 are the threshold, zero-extended to 32 bits and shown on `thr_o`.
- R3: Base-relative form (`wait_base_i`=1): bits 31:24 select the sync point, bits 23:16 select a base register and bits 15:0 are an offset. The threshold is the base content plus the zero-extended offset, modulo 2^32.
- R4: A wait is met when bit 31 of (counter - threshold) mod 2^32 is 0. A counter one below the threshold does not meet the wait.
- R5: The met state is registered. `done_o` rises in the cycle right after the clock edge that applies either the accepting wait word or the increment that meets the wait.
- R6: While a wait is pending and not met, `busy_o`=1 and `wait_ready_o`=0. A `wait_valid_i` presented in that state is ignored, and the stored word is unchanged.
- R7: `done_o` is high for exactly one cycle. In the next cycle `busy_o`=0 and `wait_ready_o`=1.
- R8: While pending, `dbg_class_o` is HOST_CLASS (default 8'h01), `dbg_method_o` is 12'h008 for the direct form or 12'h009 for the base-relative form, and `dbg_word_o` is the stored word. When idle all three are 0.
- R9: A sync point index at or above NUM_SYNCPT, or a base index at or above NUM_BASE in the base-relative form, makes the wait met at once. `err_o` is 1 while that wait is pending and 0 after its release.
- R10: Each cycle with `incr_valid_i`=1 adds one to the counter selected by `incr_id_i` and to no other counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| incr_valid_i | input | 1 | Increment strobe |
| incr_id_i | input | 8 | Sync point to increment |
| base_we_i | input | 1 | Base register write enable |
| base_idx_i | input | 8 | Base register index |
| base_data_i | input | 32 | Base register write value |
| wait_valid_i | input | 1 | Wait word offered |
| wait_base_i | input | 1 | 1 = base-relative form, 0 = direct form |
| wait_word_i | input | 32 | Wait command word |
| wait_ready_o | output | 1 | A new wait can be accepted |
| busy_o | output | 1 | A wait is pending (stream stalled) |
| done_o | output | 1 | One-cycle pulse: pending wait met |
| err_o | output | 1 | Pending wait has an out-of-range index |
| thr_o | output | 32 | Effective threshold of the pending wait |
| dbg_class_o | output | 8 | Class of the blocked channel |
| dbg_method_o | output | 12 | Method offset of the pending wait |
| dbg_word_o | output | 32 | Stored wait word |

## Verification
The bench builds the block with NUM_SYNCPT=4 and NUM_BASE=2. With these values, small values in the 8-bit index fields already fall outside the implemented banks, so the out-of-range error path can be reached cheaply. Base values near 2^31 and 2^32 make the threshold addition wrap and push the counter difference across its sign bit, without billions of increments. This exposes both the wraparound behaviour and the modular comparison in a few hundred cycles.

// File: rtl/syncpt_pkg.sv
package syncpt_pkg;
  localparam int WORD_W = 32;
  localparam int IDX_W  = 8;

  typedef enum logic {
    WAIT_DIRECT = 1'b0,
    WAIT_BASE   = 1'b1
  } wait_kind_e;

  // met when counter - threshold is non-negative as a signed value
  function automatic logic reached(input logic [WORD_W-1:0] cnt,
                                   input logic [WORD_W-1:0] thr);
    logic [WORD_W-1:0] diff;
    diff = cnt - thr;
    return ~diff[WORD_W-1];
  endfunction
endpackage

// File: rtl/syncpt_cnt_bank.sv
module syncpt_cnt_bank
  import syncpt_pkg::*;
#(
  parameter int NUM = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       inc_en_i,
  input  logic [IDX_W-1:0]           inc_id_i,
  output logic [NUM-1:0][WORD_W-1:0] cnt_d_o
);
  logic [NUM-1:0][WORD_W-1:0] cnt_q;

  for (genvar g = 0; g < NUM; g++) begin : g_cnt
    logic hit;
    assign hit        = inc_en_i && (inc_id_i == IDX_W'(g));
    assign cnt_d_o[g] = cnt_q[g] + {{(WORD_W-1){1'b0}}, hit};
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q[g] <= '0;
      else         cnt_q[g] <= cnt_d_o[g];
    end
  end
endmodule

// File: rtl/syncpt_base_bank.sv
module syncpt_base_bank
  import syncpt_pkg::*;
#(
  parameter int NUM = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [IDX_W-1:0]           idx_i,
  input  logic [WORD_W-1:0]          data_i,
  output logic [NUM-1:0][WORD_W-1:0] base_d_o
);
  logic [NUM-1:0][WORD_W-1:0] base_q;

  for (genvar g = 0; g < NUM; g++) begin : g_base
    assign base_d_o[g] = (we_i && idx_i == IDX_W'(g)) ? data_i : base_q[g];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) base_q[g] <= '0;
      else         base_q[g] <= base_d_o[g];
    end
  end
endmodule

// File: rtl/syncpt_wait_cmp.sv
module syncpt_wait_cmp
  import syncpt_pkg::*;
#(
  parameter int NUM_SYNCPT = 16,
  parameter int NUM_BASE   = 8
) (
  input  logic [WORD_W-1:0]                 word_i,
  input  wait_kind_e                        kind_i,
  input  logic [NUM_SYNCPT-1:0][WORD_W-1:0] cnt_i,
  input  logic [NUM_BASE-1:0][WORD_W-1:0]   base_i,
  output logic [WORD_W-1:0]                 thr_o,
  output logic                              met_o,
  output logic                              err_o
);
  localparam logic [IDX_W:0] SP_LIM   = (IDX_W+1)'(NUM_SYNCPT);
  localparam logic [IDX_W:0] BASE_LIM = (IDX_W+1)'(NUM_BASE);

  logic [IDX_W-1:0]  sp_idx, b_idx;
  logic [15:0]       ofs;
  logic              sp_bad, base_bad;
  logic [WORD_W-1:0] cnt_val, base_val;

  assign sp_idx = word_i[31:24];
  assign b_idx  = word_i[23:16];
  assign ofs    = word_i[15:0];

  assign sp_bad   = {1'b0, sp_idx} >= SP_LIM;
  assign base_bad = (kind_i == WAIT_BASE) && ({1'b0, b_idx} >= BASE_LIM);

  always_comb begin
    cnt_val = '0;
    for (int i = 0; i < NUM_SYNCPT; i++)
      if (sp_idx == IDX_W'(i)) cnt_val = cnt_i[i];
  end

  always_comb begin
    base_val = '0;
    for (int i = 0; i < NUM_BASE; i++)
      if (b_idx == IDX_W'(i)) base_val = base_i[i];
  end

  always_comb begin
    if (kind_i == WAIT_BASE) thr_o = base_val + {16'h0, ofs};
    else                     thr_o = {8'h0, word_i[23:0]};
  end

  assign err_o = sp_bad | base_bad;
  assign met_o = err_o | reached(cnt_val, thr_o);
endmodule

// File: rtl/syncpt_wait_eval.sv
module syncpt_wait_eval
  import syncpt_pkg::*;
#(
  parameter int          NUM_SYNCPT    = 16,
  parameter int          NUM_BASE      = 8,
  parameter logic [7:0]  HOST_CLASS    = 8'h01,
  parameter logic [11:0] METHOD_DIRECT = 12'h008,
  parameter logic [11:0] METHOD_BASE   = 12'h009
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        incr_valid_i,
  input  logic [7:0]  incr_id_i,
  input  logic        base_we_i,
  input  logic [7:0]  base_idx_i,
  input  logic [31:0] base_data_i,
  input  logic        wait_valid_i,
  input  logic        wait_base_i,
  input  logic [31:0] wait_word_i,
  output logic        wait_ready_o,
  output logic        busy_o,
  output logic        done_o,
  output logic        err_o,
  output logic [31:0] thr_o,
  output logic [7:0]  dbg_class_o,
  output logic [11:0] dbg_method_o,
  output logic [31:0] dbg_word_o
);
  logic [NUM_SYNCPT-1:0][WORD_W-1:0] cnt_d;
  logic [NUM_BASE-1:0][WORD_W-1:0]   base_d;

  logic              pend_q, pend_d;
  logic              met_q, err_q;
  wait_kind_e        kind_q, kind_d;
  logic [WORD_W-1:0] word_q, word_d, thr_q, thr_c;
  logic              met_c, err_c, accept;

  syncpt_cnt_bank #(.NUM(NUM_SYNCPT)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .inc_en_i (incr_valid_i),
    .inc_id_i (incr_id_i),
    .cnt_d_o  (cnt_d)
  );

  syncpt_base_bank #(.NUM(NUM_BASE)) u_base (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (base_we_i),
    .idx_i    (base_idx_i),
    .data_i   (base_data_i),
    .base_d_o (base_d)
  );

  // evaluate against next-state values so the flag lands one cycle after the cause
  syncpt_wait_cmp #(.NUM_SYNCPT(NUM_SYNCPT), .NUM_BASE(NUM_BASE)) u_cmp (
    .word_i (word_d),
    .kind_i (kind_d),
    .cnt_i  (cnt_d),
    .base_i (base_d),
    .thr_o  (thr_c),
    .met_o  (met_c),
    .err_o  (err_c)
  );

  assign accept = wait_valid_i & ~pend_q;
  assign pend_d = accept | (pend_q & ~met_q);
  assign word_d = accept ? wait_word_i : word_q;
  assign kind_d = accept ? wait_kind_e'(wait_base_i) : kind_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      met_q  <= 1'b0;
      err_q  <= 1'b0;
      kind_q <= WAIT_DIRECT;
      word_q <= '0;
      thr_q  <= '0;
    end else begin
      pend_q <= pend_d;
      met_q  <= pend_d & met_c;
      err_q  <= pend_d & err_c;
      kind_q <= kind_d;
      word_q <= word_d;
      thr_q  <= pend_d ? thr_c : '0;
    end
  end

  assign wait_ready_o = ~pend_q;
  assign busy_o       = pend_q;
  assign done_o       = met_q;
  assign err_o        = err_q;
  assign thr_o        = thr_q;
  assign dbg_class_o  = pend_q ? HOST_CLASS : 8'h0;
  assign dbg_method_o = !pend_q ? 12'h0 :
                        (kind_q == WAIT_BASE) ? METHOD_BASE : METHOD_DIRECT;
  assign dbg_word_o   = pend_q ? word_q : '0;
endmodule

// File: rtl/syncpt_wait_eval_chk.sv
module syncpt_wait_eval_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wait_valid_i,
  input logic        wait_ready_o,
  input logic        busy_o,
  input logic        done_o,
  input logic        err_o,
  input logic [7:0]  dbg_class_o,
  input logic [31:0] dbg_word_o
);
  // R5
  accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_ready_o && wait_valid_i |=> busy_o);

  // R6
  hold_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_o |=> busy_o && $stable(dbg_word_o));

  // R7
  done_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o && wait_ready_o);

  // R9
  err_met_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);

  // R8
  idle_dbg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> dbg_class_o == 8'h0 && dbg_word_o == 32'h0);
endmodule

bind syncpt_wait_eval syncpt_wait_eval_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wait_valid_i (wait_valid_i),
  .wait_ready_o (wait_ready_o),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .err_o        (err_o),
  .dbg_class_o  (dbg_class_o),
  .dbg_word_o   (dbg_word_o)
);

// File: tb/syncpt_wait_eval_tb.sv
`timescale 1ns/1ps
module syncpt_wait_eval_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        incr_valid, base_we, wait_valid, wait_base;
  logic [7:0]  incr_id, base_idx;
  logic [31:0] base_data, wait_word;
  logic        wait_ready, busy, done, err;
  logic [31:0] thr, dbg_word;
  logic [7:0]  dbg_class;
  logic [11:0] dbg_method;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;
  logic [32:0] exp_q[$];
  logic [32:0] exp_e;

  always #4 clk = ~clk;

  syncpt_wait_eval #(.NUM_SYNCPT(4), .NUM_BASE(2)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .incr_valid_i(incr_valid), .incr_id_i(incr_id),
    .base_we_i(base_we), .base_idx_i(base_idx), .base_data_i(base_data),
    .wait_valid_i(wait_valid), .wait_base_i(wait_base), .wait_word_i(wait_word),
    .wait_ready_o(wait_ready), .busy_o(busy), .done_o(done), .err_o(err),
    .thr_o(thr), .dbg_class_o(dbg_class), .dbg_method_o(dbg_method),
    .dbg_word_o(dbg_word)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the expected item on each done pulse
  always @(negedge clk) begin
    if (rst_n && done && !finished) begin
      if (exp_q.size() == 0) begin
        check("R7 unexpected done", 32'(done), 32'h0);
      end else begin
        exp_e = exp_q.pop_front();
        check("R7 done word", dbg_word, exp_e[31:0]);
        check("R9 err at done", 32'(err), 32'(exp_e[32]));
      end
    end
  end

  task automatic expect_done(input logic [31:0] w, input logic e);
    exp_q.push_back({e, w});
  endtask

  task automatic issue(input logic b, input logic [31:0] w);
    wait_valid = 1'b1; wait_base = b; wait_word = w;
    @(negedge clk);
    wait_valid = 1'b0;
  endtask

  task automatic incr(input logic [7:0] id, input int n);
    incr_valid = 1'b1; incr_id = id;
    repeat (n) @(negedge clk);
    incr_valid = 1'b0;
  endtask

  task automatic load_base(input logic [7:0] idx, input logic [31:0] v);
    base_we = 1'b1; base_idx = idx; base_data = v;
    @(negedge clk);
    base_we = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; incr_valid = 0; incr_id = 0; base_we = 0; base_idx = 0;
    base_data = 0; wait_valid = 0; wait_base = 0; wait_word = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 ready", 32'(wait_ready), 32'h1);
    check("R1 busy", 32'(busy), 32'h0);
    check("R1 done", 32'(done), 32'h0);
    check("R1 err", 32'(err), 32'h0);
    check("R1 dbg_class", 32'(dbg_class), 32'h0);
    check("R1 thr", thr, 32'h0);

    // R2 direct wait on sp0, threshold 3
    issue(1'b0, {8'd0, 24'd3});
    check("R6 busy", 32'(busy), 32'h1);
    check("R6 ready low", 32'(wait_ready), 32'h0);
    check("R2 thr", thr, 32'h3);
    check("R8 class", 32'(dbg_class), 32'h01);
    check("R8 direct method", 32'(dbg_method), 32'h008);
    check("R8 word", dbg_word, {8'd0, 24'd3});
    incr(8'd0, 2);
    check("R4 below threshold", 32'(done), 32'h0);
    check("R6 still busy", 32'(busy), 32'h1);
    expect_done({8'd0, 24'd3}, 1'b0);
    incr(8'd0, 1);
    check("R5 done after incr", 32'(done), 32'h1);
    @(negedge clk);
    check("R7 pulse ends", 32'(done), 32'h0);
    check("R7 released", 32'(wait_ready), 32'h1);

    // R6 new wait ignored while pending
    issue(1'b0, {8'd1, 24'd1});
    issue(1'b0, {8'd1, 24'd0});
    check("R6 word kept", dbg_word, {8'd1, 24'd1});
    check("R6 no done", 32'(done), 32'h0);
    expect_done({8'd1, 24'd1}, 1'b0);
    incr(8'd1, 1);
    check("R10 sp1 incr", 32'(done), 32'h1);
    @(negedge clk);

    // R5 already met at accept
    expect_done({8'd2, 24'd0}, 1'b0);
    issue(1'b0, {8'd2, 24'd0});
    check("R5 immediate done", 32'(done), 32'h1);
    @(negedge clk);

    // R3 base-relative: base0=10, offset 2, sp0=3
    load_base(8'd0, 32'd10);
    issue(1'b1, {8'd0, 8'd0, 16'd2});
    check("R3 thr", thr, 32'd12);
    check("R8 base method", 32'(dbg_method), 32'h009);
    incr(8'd0, 8);
    check("R4 one below", 32'(done), 32'h0);
    expect_done({8'd0, 8'd0, 16'd2}, 1'b0);
    incr(8'd0, 1);
    check("R4 at threshold", 32'(done), 32'h1);
    @(negedge clk);

    // R3 threshold wrap: base1=FFFFFFF0 + 0x20 = 0x10
    load_base(8'd1, 32'hFFFF_FFF0);
    issue(1'b1, {8'd3, 8'd1, 16'h0020});
    check("R3 wrapped thr", thr, 32'h10);
    incr(8'd3, 15);
    check("R4 wrap not met", 32'(done), 32'h0);
    expect_done({8'd3, 8'd1, 16'h0020}, 1'b0);
    incr(8'd3, 1);
    check("R4 wrap met", 32'(done), 32'h1);
    @(negedge clk);

    // R4 modular: thr 0x80000001, sp2=0, difference 0x7FFFFFFF counts as met
    load_base(8'd1, 32'h7FFF_FFF0);
    expect_done({8'd2, 8'd1, 16'h0011}, 1'b0);
    issue(1'b1, {8'd2, 8'd1, 16'h0011});
    check("R4 modular met", 32'(done), 32'h1);
    check("R3 thr far", thr, 32'h8000_0001);
    @(negedge clk);

    // R9 sync point out of range
    expect_done({8'd4, 24'd5}, 1'b1);
    issue(1'b0, {8'd4, 24'd5});
    check("R9 err sp", 32'(err), 32'h1);
    check("R9 done sp", 32'(done), 32'h1);
    @(negedge clk);
    check("R9 err cleared", 32'(err), 32'h0);

    // R9 base index out of range
    expect_done({8'd0, 8'd2, 16'd0}, 1'b1);
    issue(1'b1, {8'd0, 8'd2, 16'd0});
    check("R9 err base", 32'(err), 32'h1);
    @(negedge clk);

    // R10 increment of another counter does not satisfy
    issue(1'b0, {8'd1, 24'd2});
    incr(8'd0, 1);
    check("R10 other counter", 32'(done), 32'h0);
    expect_done({8'd1, 24'd2}, 1'b0);
    incr(8'd1, 1);
    check("R10 own counter", 32'(done), 32'h1);
    @(negedge clk);

    check("R7 all done seen", 32'(exp_q.size()), 32'h0);
    finish_run();
  end
endmodule